// File: doc/BRIEF.md
# E1 Receive Frame Aligner

This block watches a 2.048 Mb/s E1 receive bit stream, one bit per clock, and locks onto the 256-bit frame structure. It finds the frame alignment word in timeslot 0 and holds alignment while the word keeps arriving. It declares alignment lost after a set number of consecutive errored checks and then either hunts again at once or waits for a manual restart. While aligned it emits a one-clock sync pulse on every frame boundary, or only on multiframe boundaries. The multiframe is either the channel-associated-signalling type or the CRC4 type.

Timeslot 0 bits are numbered 1 to 8 in arrival order. Even frames carry the alignment word `0011011` in bits 2 to 8. Odd frames carry a 1 in bit 2. The state machine has five states. SEARCH hunts bit by bit for the alignment word. VFY_NFAS checks bit 2 of the following frame. VFY_FAS checks the alignment word one frame later. SYNCED monitors each frame. HOLD waits after a loss when automatic restart is disabled.

The transitions are as follows:
- *found*: SEARCH to VFY_NFAS.
- *nfas_ok*: VFY_NFAS to VFY_FAS.
- *nfas_bad*: VFY_NFAS to SEARCH.
- *locked*: VFY_FAS to SYNCED.
- *fas_bad*: VFY_FAS to SEARCH.
- *lost_auto*: SYNCED to SEARCH.
- *lost_hold*: SYNCED to HOLD.
- *manual*: any state to SEARCH.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset or a restart, `in_sync_o` goes high only after three checks pass in order. The first is an alignment word match. The second is bit 2 = 1 in the next frame. The third is an alignment word match in the frame after that. It goes high in the clock that samples bit 8 of the third frame.
- R2: With `cfg_mf_mode_i` = 0 and `in_sync_o` high, `sync_o` is high for exactly one clock per frame. That clock is the one right after the edge that sampled the frame's last bit.
- R3: With `cfg_crit_i` = 0, only the alignment word of even frames is checked, and a wrong bit 2 in odd frames has no effect. The third consecutive errored word drops `in_sync_o` and pulses `loss_o` for one clock, both in the clock that samples bit 8 of that word.
- R4: With `cfg_crit_i` = 1, odd frames whose bit 2 is 0 also count as errors. Any three consecutive errored checks, of either kind, cause loss as in R3.
- R5: Any correctly received checked word resets the error count to zero. Two errors, then a good word, then two errors, do not cause loss.
- R6: With `cfg_auto_dis_i` = 0, the search restarts right after a loss. Alignment is regained per R1 from the next good alignment word.
- R7: With `cfg_auto_dis_i` = 1, the block stays out of alignment after a loss, even while good frames arrive, until a restart request.
- R8: A 0-to-1 change of `cfg_resync_i` forces a new search from any state, and drops `in_sync_o` in that same clock. Keeping the input at 1 has no further effect.
- R9: With `cfg_mf_mode_i` = 1 and `cfg_mf_crc4_i` = 0, sync pulses mark only the end of signalling multiframe frame 15. Frame 0 of that multiframe is the frame whose timeslot 16 bits 1 to 4 are `0000`.
- R10: With `cfg_mf_mode_i` = 1 and `cfg_mf_crc4_i` = 1, sync pulses mark only the end of CRC4 multiframe frame 15. Frame 11 is the one that completes `001011` in bit 1 of the last six odd frames.
- R11: During reset `in_sync_o`, `sync_o` and `loss_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial receive data, one bit per clock |
| cfg_crit_i | input | 1 | 1: odd-frame bit 2 errors count toward loss |
| cfg_auto_dis_i | input | 1 | 1: no automatic search after loss |
| cfg_resync_i | input | 1 | Rising edge forces a new search |
| cfg_mf_mode_i | input | 1 | 0: frame pulses, 1: multiframe pulses |
| cfg_mf_crc4_i | input | 1 | Multiframe type: 0 signalling, 1 CRC4 |
| in_sync_o | output | 1 | Frame alignment held |
| sync_o | output | 1 | One-clock boundary pulse |
| loss_o | output | 1 | One-clock pulse when alignment is declared lost |

## Verification
Some properties are checked on every cycle. A loss pulse always coincides with a falling `in_sync_o`. Alignment is only ever gained from the word-verify state. A restart edge always lands in SEARCH. HOLD is left only through a restart. A sync pulse never appears outside alignment. A multiframe tracker is clear whenever alignment is absent.

The exact timing of alignment and loss needs the bench's scenarios, and so does the choice of error criterion. The same holds for the counter reset on a good word, the one-shot nature of a held restart request, and the frame in which each multiframe type places its pulse. There the stream carries deliberately corrupted words, and both multiframe markers are placed at different frame offsets.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

    typedef enum logic [2:0] {
        ST_SEARCH,
        ST_VFY_NFAS,
        ST_VFY_FAS,
        ST_SYNCED,
        ST_HOLD
    } align_st_e;

    // alignment word, bits 2..8 of timeslot 0 in even frames
    localparam logic [6:0] FAS_WORD = 7'b0011011;
    // CRC4 multiframe marker, bit 1 of six successive odd frames
    localparam logic [5:0] CRC_MFAS = 6'b001011;

endpackage

// File: rtl/e1fa_timebase.sv
module e1fa_timebase #(
    parameter int FRAME_BITS = 256,
    parameter int LOAD_POS   = 8,
    localparam int PW        = $clog2(FRAME_BITS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    output logic [PW-1:0] pos_o,
    output logic          fas_frame_o,
    output logic          frame_end_o
);

    assign frame_end_o = (pos_o == PW'(FRAME_BITS - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_o       <= '0;
            fas_frame_o <= 1'b0;
        end else if (load_i) begin
            pos_o       <= PW'(LOAD_POS);
            fas_frame_o <= 1'b1;
        end else if (frame_end_o) begin
            pos_o       <= '0;
            fas_frame_o <= ~fas_frame_o;
        end else begin
            pos_o <= pos_o + 1'b1;
        end
    end

endmodule

// File: rtl/e1fa_mf_track.sv
module e1fa_mf_track #(
    parameter int MF_FRAMES  = 16,
    parameter int MARK_FRAME = 0,
    localparam int FW        = $clog2(MF_FRAMES)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic mark_i,
    input  logic frame_end_i,
    output logic locked_o,
    output logic last_o
);

    logic [FW-1:0] fn_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fn_q     <= '0;
            locked_o <= 1'b0;
        end else if (!en_i) begin
            fn_q     <= '0;
            locked_o <= 1'b0;
        end else if (mark_i) begin
            fn_q     <= FW'(MARK_FRAME);
            locked_o <= 1'b1;
        end else if (frame_end_i && locked_o) begin
            fn_q <= (fn_q == FW'(MF_FRAMES - 1)) ? '0 : fn_q + 1'b1;
        end
    end

    assign last_o = locked_o && (fn_q == FW'(MF_FRAMES - 1));

    // R9
    mf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !locked_o);

endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    parameter int LOSS_LIMIT = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_bit_i,
    input  logic cfg_crit_i,
    input  logic cfg_auto_dis_i,
    input  logic cfg_resync_i,
    input  logic cfg_mf_mode_i,
    input  logic cfg_mf_crc4_i,
    output logic in_sync_o,
    output logic sync_o,
    output logic loss_o
);

    localparam int PW         = $clog2(FRAME_BITS);
    localparam int EW         = $clog2(LOSS_LIMIT + 1);
    localparam int TS0_LAST   = 7;
    localparam int TS16_LAST  = 16 * 8 + 3;
    localparam int MFAS_FRAME = MF_FRAMES - 5;

    align_st_e     st_q, st_d;
    logic [EW-1:0] err_q, err_d;
    logic [6:0]    hist_q;
    logic [5:0]    crc_hist_q;
    logic          resync_prev_q;
    logic          resync_rise, load, loss_d;
    logic [PW-1:0] pos;
    logic          fas_frame, frame_end;
    logic [6:0]    win;
    logic          fas_ok, bit1, bit2, chk, word_ok;
    logic [1:0]    mf_mark, mf_locked, mf_last;

    assign win         = {hist_q[5:0], rx_bit_i};
    assign fas_ok      = (win == FAS_WORD);
    assign bit2        = hist_q[5];
    assign bit1        = hist_q[6];
    assign chk         = (pos == PW'(TS0_LAST));
    assign word_ok     = fas_frame ? fas_ok : bit2;
    assign resync_rise = cfg_resync_i && !resync_prev_q;

    e1fa_timebase #(
        .FRAME_BITS (FRAME_BITS),
        .LOAD_POS   (TS0_LAST + 1)
    ) u_timebase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .pos_o       (pos),
        .fas_frame_o (fas_frame),
        .frame_end_o (frame_end)
    );

    // multiframe markers: [0] signalling, [1] CRC4
    assign mf_mark[0] = in_sync_o && (pos == PW'(TS16_LAST))
                        && ({hist_q[2:0], rx_bit_i} == 4'b0000);
    assign mf_mark[1] = in_sync_o && chk && !fas_frame
                        && ({crc_hist_q[4:0], bit1} == CRC_MFAS);

    for (genvar g = 0; g < 2; g++) begin : g_mf
        e1fa_mf_track #(
            .MF_FRAMES  (MF_FRAMES),
            .MARK_FRAME ((g == 0) ? 0 : MFAS_FRAME)
        ) u_track (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .en_i        (in_sync_o),
            .mark_i      (mf_mark[g]),
            .frame_end_i (frame_end),
            .locked_o    (mf_locked[g]),
            .last_o      (mf_last[g])
        );
    end

    // next state
    always_comb begin
        st_d   = st_q;
        err_d  = err_q;
        loss_d = 1'b0;
        load   = 1'b0;
        if (resync_rise) begin
            st_d  = ST_SEARCH;
            err_d = '0;
        end else begin
            unique case (st_q)
                ST_SEARCH: begin
                    if (fas_ok) begin
                        st_d  = ST_VFY_NFAS;
                        load  = 1'b1;
                        err_d = '0;
                    end
                end
                ST_VFY_NFAS: if (chk) st_d = bit2 ? ST_VFY_FAS : ST_SEARCH;
                ST_VFY_FAS:  if (chk) st_d = fas_ok ? ST_SYNCED : ST_SEARCH;
                ST_SYNCED: begin
                    if (chk && (fas_frame || cfg_crit_i)) begin
                        if (word_ok) begin
                            err_d = '0;
                        end else if (err_q == EW'(LOSS_LIMIT - 1)) begin
                            err_d  = '0;
                            loss_d = 1'b1;
                            st_d   = cfg_auto_dis_i ? ST_HOLD : ST_SEARCH;
                        end else begin
                            err_d = err_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: st_d = ST_HOLD;
                default: st_d = ST_SEARCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= ST_SEARCH;
            err_q         <= '0;
            hist_q        <= '1;
            resync_prev_q <= 1'b0;
            crc_hist_q    <= '1;
        end else begin
            st_q          <= st_d;
            err_q         <= err_d;
            hist_q        <= win;
            resync_prev_q <= cfg_resync_i;
            if (!in_sync_o)
                crc_hist_q <= '1;
            else if (chk && !fas_frame)
                crc_hist_q <= {crc_hist_q[4:0], bit1};
        end
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            in_sync_o <= 1'b0;
            sync_o    <= 1'b0;
            loss_o    <= 1'b0;
        end else begin
            in_sync_o <= (st_d == ST_SYNCED);
            loss_o    <= loss_d;
            sync_o    <= (st_q == ST_SYNCED) && !resync_rise && frame_end
                         && (!cfg_mf_mode_i
                             || (cfg_mf_crc4_i ? mf_last[1] : mf_last[0]));
        end
    end

    // R1
    rise_from_verify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(in_sync_o) |-> ($past(st_q) == ST_VFY_FAS));
    // R2
    sync_in_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_o |-> in_sync_o);
    // R3
    loss_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loss_o |-> (!in_sync_o && $past(in_sync_o)));
    // R7
    hold_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == ST_HOLD) && !resync_rise) |=> (st_q == ST_HOLD));
    // R8
    resync_search_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync_rise |=> (st_q == ST_SEARCH));

endmodule

// File: tb/e1_frame_aligner_bench.sv
module e1_frame_aligner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FB         = 256;
    localparam int OFF        = 100;
    localparam int NF         = 160;
    localparam logic [5:0] MFAS_SEQ = 6'b001011;

    typedef enum int {EV_RISE, EV_FALL, EV_LOSS, EV_SYNC} ev_e;
    typedef struct {
        int    cyc;
        ev_e   kind;
        string tag;
    } ev_t;

    logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
    logic crit = 1'b0, adis = 1'b0, rsy = 1'b0, mfm = 1'b0, crc = 1'b0;
    logic in_sync, sync_p, loss_p;

    ev_t   exp_q[$];
    ev_t   plan_q[$];
    bit    fas_bad[NF];
    bit    nfas_bad[NF];
    string sync_tag[NF];
    int    n_chk = 0, n_fail = 0, k = 0;
    logic  prev_lvl = 1'b0;
    bit    done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    e1_frame_aligner u_e1_frame_aligner (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .rx_bit_i       (rx),
        .cfg_crit_i     (crit),
        .cfg_auto_dis_i (adis),
        .cfg_resync_i   (rsy),
        .cfg_mf_mode_i  (mfm),
        .cfg_mf_crc4_i  (crc),
        .in_sync_o      (in_sync),
        .sync_o         (sync_p),
        .loss_o         (loss_p)
    );

    function automatic int cy(int f, int p);
        return f * FB + p - OFF;
    endfunction

    // stream: even frames carry the alignment word, CRC4 frame 0 at f%16==0,
    // signalling frame 0 at f%16==4
    function automatic logic gen_bit(int g);
        int f = g / FB;
        int p = g % FB;
        int ts = p / 8;
        int b = p % 8;
        logic [7:0] w = 8'hFF;
        if (ts == 0) begin
            if (f % 2 == 0) begin
                w = 8'b1001_1011;
                if (fas_bad[f]) w[3] = 1'b0;
            end else begin
                w = 8'b1101_1111;
                if (f % 16 <= 11) w[7] = MFAS_SEQ[5 - (f % 16 - 1) / 2];
                if (nfas_bad[f]) w[6] = 1'b0;
            end
        end else if (ts == 16 && f % 16 == 4) begin
            w = 8'b0000_1011;
        end
        return w[7 - b];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic plan(input int c, input ev_e kd, input string tag);
        plan_q.push_back('{c, kd, tag});
    endtask

    task automatic match(input ev_e kd, input string dflt);
        int hit = -1;
        foreach (exp_q[i])
            if (hit < 0 && exp_q[i].cyc == k && exp_q[i].kind == kd) hit = i;
        if (hit >= 0) begin
            check(1'b1, exp_q[hit].tag, kd.name(), k, k);
            exp_q.delete(hit);
        end else begin
            check(1'b0, dflt, {"unexpected ", kd.name(), " cycle"}, k, -1);
        end
    endtask

    task automatic observe();
        if (in_sync && !prev_lvl) match(EV_RISE, "R1");
        if (!in_sync && prev_lvl) match(EV_FALL, "R3");
        if (loss_p) match(EV_LOSS, "R3");
        if (sync_p) match(EV_SYNC, "R2");
        prev_lvl = in_sync;
        while (exp_q.size() > 0 && exp_q[0].cyc <= k) begin
            check(1'b0, exp_q[0].tag, {"missing ", exp_q[0].kind.name(), " cycle"},
                  -1, exp_q[0].cyc);
            void'(exp_q.pop_front());
        end
    endtask

    task automatic run_to(input int kend);
        while (k < kend && !done) begin
            rx = gen_bit(k + OFF);
            while (plan_q.size() > 0 && plan_q[0].cyc == k)
                exp_q.push_back(plan_q.pop_front());
            if ((k + OFF) % FB == FB - 1 && sync_tag[(k + OFF) / FB] != "")
                exp_q.push_back('{k, EV_SYNC, sync_tag[(k + OFF) / FB]});
            @(negedge clk);
            observe();
            k++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        foreach (sync_tag[i]) sync_tag[i] = "";
        for (int f = 4;  f <= 35; f++) sync_tag[f] = "R2";
        for (int f = 40; f <= 44; f++) sync_tag[f] = "R2";
        for (int f = 48; f <= 55; f++) sync_tag[f] = "R2";
        for (int f = 66; f <= 72; f++) sync_tag[f] = "R2";
        sync_tag[76] = "R2";
        sync_tag[77] = "R2";
        sync_tag[99] = "R9";
        sync_tag[115] = "R9";
        sync_tag[127] = "R10";
        sync_tag[143] = "R10";
        // R5 pattern, R3 loss, R4 mixed loss, R7 loss
        fas_bad[10] = 1; fas_bad[12] = 1; fas_bad[16] = 1; fas_bad[18] = 1;
        fas_bad[32] = 1; fas_bad[34] = 1; fas_bad[36] = 1;
        fas_bad[44] = 1;
        fas_bad[52] = 1; fas_bad[54] = 1; fas_bad[56] = 1;
        nfas_bad[23] = 1; nfas_bad[25] = 1; nfas_bad[27] = 1;
        nfas_bad[43] = 1; nfas_bad[45] = 1;

        plan(cy(4, 7),    EV_RISE, "R1");
        plan(cy(36, 7),   EV_FALL, "R3");
        plan(cy(36, 7),   EV_LOSS, "R3");
        plan(cy(40, 7),   EV_RISE, "R6");
        plan(cy(45, 7),   EV_FALL, "R4");
        plan(cy(45, 7),   EV_LOSS, "R4");
        plan(cy(48, 7),   EV_RISE, "R6");
        plan(cy(56, 7),   EV_FALL, "R7");
        plan(cy(56, 7),   EV_LOSS, "R7");
        plan(cy(66, 7),   EV_RISE, "R8");
        plan(cy(73, 100), EV_FALL, "R8");
        plan(cy(76, 7),   EV_RISE, "R8");

        repeat (3) @(negedge clk);
        check(in_sync == 1'b0, "R11", "in_sync in reset", int'(in_sync), 0);
        check(sync_p == 1'b0,  "R11", "sync in reset",    int'(sync_p),  0);
        check(loss_p == 1'b0,  "R11", "loss in reset",    int'(loss_p),  0);
        rst_n = 1'b1;

        run_to(cy(21, 0));
        check(in_sync == 1'b1, "R5", "in_sync after split errors", int'(in_sync), 1);
        run_to(cy(28, 0));
        check(in_sync == 1'b1, "R3", "in_sync after odd bit2 errors", int'(in_sync), 1);
        run_to(cy(41, 100));
        crit = 1'b1;
        run_to(cy(49, 100));
        crit = 1'b0;
        adis = 1'b1;
        run_to(cy(62, 200));
        check(in_sync == 1'b0, "R7", "in_sync while held", int'(in_sync), 0);
        run_to(cy(63, 100));
        rsy = 1'b1;
        run_to(cy(72, 100));
        check(in_sync == 1'b1, "R8", "in_sync with restart held high", int'(in_sync), 1);
        rsy = 1'b0;
        run_to(cy(73, 100));
        rsy = 1'b1;
        run_to(cy(76, 100));
        adis = 1'b0;
        run_to(cy(78, 100));
        mfm = 1'b1;
        run_to(cy(120, 100));
        crc = 1'b1;
        run_to(cy(150, 0));

        while (exp_q.size() > 0) begin
            check(1'b0, exp_q[0].tag, "missing event at end", -1, exp_q[0].cyc);
            void'(exp_q.pop_front());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", k, cy(150, 0));
            summary();
            $finish;
        end
    end

endmodule